// File: doc/BRIEF.md
# DMA Page-Table Address Translator

This block turns a 32-bit logical address issued by a DMA device into a physical memory address. Software programs two registers: the byte address where a single-level page table starts, and the table length in bytes. Each table slot is eight bytes. The first 32-bit word of a slot holds the physical frame, and the second word is not used here. A logical page is 4096 bytes.

For each accepted request, the block computes the page index and checks it against the number of slots the length register allows. If the index is in range, it reads the frame word from memory through a request/acknowledge port. It then returns the frame, with its low bits replaced by the page offset of the request. An index out of range, or a read that reports an error, produces a response with the fault bit set and an address of zero. Only one translation is in flight at a time.

The controller is a three-state machine:
- **IDLE** accepts a request. IDLE goes to **FETCH** when the index is in range, or straight to **REPLY** when it is out of range.
- **FETCH** holds the memory read until it is acknowledged, then goes to **REPLY**.
- **REPLY** presents the response until the consumer takes it, then goes back to **IDLE**.

Top module: `dma_xlate`

## Requirements
- R1: After reset, req_ready is 1, and mem_req and rsp_valid are 0. The base and limit registers reset to 0, so a first request faults without any memory read.
- R2: req_ready is 1 only in IDLE. A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready then stays 0 until that request's response has been consumed.
- R3: The page index is req_addr[31:12]. A translation is in range only when the index is strictly less than floor(limit / 8). An out-of-range request responds with rsp_fault = 1 and issues no memory read.
- R4: For an in-range request, exactly one read is issued. Its address is mem_addr = (base AND 0x7FFFFFFF) + index * 8, modulo 2^32. mem_req stays 1 with mem_addr unchanged until mem_ack is 1.
- R5: A read acknowledged with mem_err = 0 yields rsp_fault = 0 and rsp_paddr = {mem_rdata[31:12], req_addr[11:0]}. The low 12 bits of the frame word are discarded.
- R6: A read acknowledged with mem_err = 1 yields rsp_fault = 1 and rsp_paddr = 0. Every faulting response carries rsp_paddr = 0.
- R7: Once rsp_valid is 1, rsp_valid, rsp_paddr and rsp_fault hold their values until a clock edge where rsp_ready is 1.
- R8: On a clock edge with reg_we = 1, reg_wdata is written to the base register when reg_sel = 0, and to the limit register when reg_sel = 1. A write made after a request has been accepted changes only the requests accepted later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 base, 1 limit |
| reg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Logical DMA address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 32 | Physical address, zero on fault |
| rsp_fault | output | 1 | Translation failed |
| mem_req | output | 1 | Frame-word read request |
| mem_addr | output | 32 | Byte address of the table slot |
| mem_ack | input | 1 | Read completed |
| mem_rdata | input | 32 | Frame word read from the table |
| mem_err | input | 1 | Read completed with an error |

## Verification
The bench builds the block with its default parameters: a 32-bit address, 4096-byte pages and 8-byte slots. At these values the highest page index, 0xFFFFF, can be driven directly. The base top bit that must be masked, and the carry of the slot address into bit 31, are also reachable.

Small limit values place the range boundary at a handful of pages. A limit that is not a multiple of eight is tried on each side of that boundary. Memory latency from zero to six cycles is combined with a stalling consumer, to cover the hold rules and a register write landing during a fetch.

// File: rtl/dma_xlate_pkg.sv
`timescale 1ns/1ps
package dma_xlate_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_REPLY = 2'd2
    } xl_state_e;

    localparam logic SEL_BASE  = 1'b0;
    localparam logic SEL_LIMIT = 1'b1;
endpackage

// File: rtl/dma_xlate_cfg.sv
`timescale 1ns/1ps
module dma_xlate_cfg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] tbl_base,
    output logic [DATA_W-1:0] tbl_limit
);
    import dma_xlate_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_base  <= '0;
            tbl_limit <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_BASE) tbl_base  <= wr_data;
            else                    tbl_limit <= wr_data;
        end
    end
endmodule

// File: rtl/dma_xlate_lookup.sv
`timescale 1ns/1ps
module dma_xlate_lookup #(
    parameter int ADDR_W      = 32,
    parameter int PAGE_SHIFT  = 12,
    parameter int ENTRY_SHIFT = 3
) (
    input  logic [ADDR_W-PAGE_SHIFT-1:0] page_idx,
    input  logic [ADDR_W-1:0]            tbl_base,
    input  logic [ADDR_W-1:0]            tbl_limit,
    output logic                         in_range,
    output logic [ADDR_W-1:0]            entry_addr
);
    // The top base bit never reaches the table address.
    localparam logic [ADDR_W-1:0] BASE_MASK = {1'b0, {(ADDR_W-1){1'b1}}};

    logic [ADDR_W-1:0] idx_ext;
    logic [ADDR_W-1:0] slot_count;

    assign idx_ext    = {{PAGE_SHIFT{1'b0}}, page_idx};
    assign slot_count = tbl_limit >> ENTRY_SHIFT;
    assign in_range   = idx_ext < slot_count;
    assign entry_addr = (tbl_base & BASE_MASK) + (idx_ext << ENTRY_SHIFT);
endmodule

// File: rtl/dma_xlate_ctrl.sv
`timescale 1ns/1ps
module dma_xlate_ctrl #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [PAGE_SHIFT-1:0]        req_off,
    input  logic                         in_range,
    input  logic [ADDR_W-1:0]            entry_addr,
    output logic                         rsp_valid,
    input  logic                         rsp_ready,
    output logic [ADDR_W-1:0]            rsp_paddr,
    output logic                         rsp_fault,
    output logic                         mem_req,
    output logic [ADDR_W-1:0]            mem_addr,
    input  logic                         mem_ack,
    input  logic [ADDR_W-PAGE_SHIFT-1:0] mem_frame,
    input  logic                         mem_err
);
    import dma_xlate_pkg::*;

    xl_state_e               state_q, state_d;
    logic [ADDR_W-1:0]       ent_q;
    logic [ADDR_W-1:0]       paddr_q;
    logic [PAGE_SHIFT-1:0]   off_q;
    logic                    fault_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = in_range ? ST_FETCH : ST_REPLY;
            ST_FETCH: if (mem_ack)   state_d = ST_REPLY;
            ST_REPLY: if (rsp_ready) state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready = 1'b0;
        mem_req   = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_FETCH: mem_req   = 1'b1;
            ST_REPLY: rsp_valid = 1'b1;
            default:  ;
        endcase
        mem_addr  = ent_q;
        rsp_paddr = paddr_q;
        rsp_fault = fault_q;
    end

    // Captured request and assembled result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_q   <= '0;
            off_q   <= '0;
            paddr_q <= '0;
            fault_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    ent_q   <= entry_addr;
                    off_q   <= req_off;
                    paddr_q <= '0;
                    fault_q <= !in_range;
                end
                ST_FETCH: if (mem_ack) begin
                    if (mem_err) begin
                        paddr_q <= '0;
                        fault_q <= 1'b1;
                    end else begin
                        paddr_q <= {mem_frame, off_q};
                        fault_q <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // R2: no fetch or response while open for a new request
    assert_ready_only_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req && !rsp_valid));

    // R3: an out-of-range request goes straight to a faulting response
    assert_range_skip_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !in_range) |=> (rsp_valid && rsp_fault && !mem_req));

    // R4: read request held steady until acknowledged
    assert_mem_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R6: a fault never carries an address
    assert_fault_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

    // R7: response held under backpressure
    assert_rsp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));
endmodule

// File: rtl/dma_xlate.sv
`timescale 1ns/1ps
module dma_xlate #(
    parameter int ADDR_W      = 32,
    parameter int PAGE_SHIFT  = 12,
    parameter int ENTRY_SHIFT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic              rsp_fault,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [ADDR_W-1:0] mem_rdata,
    input  logic              mem_err
);
    localparam int IDX_W = ADDR_W - PAGE_SHIFT;

    logic [ADDR_W-1:0] tbl_base, tbl_limit, entry_addr;
    logic              in_range;
    logic              unused_frame_low;

    // Low frame bits are replaced by the page offset.
    assign unused_frame_low = ^mem_rdata[PAGE_SHIFT-1:0];

    dma_xlate_cfg #(.DATA_W(ADDR_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_we),
        .wr_sel    (reg_sel),
        .wr_data   (reg_wdata),
        .tbl_base  (tbl_base),
        .tbl_limit (tbl_limit)
    );

    dma_xlate_lookup #(
        .ADDR_W      (ADDR_W),
        .PAGE_SHIFT  (PAGE_SHIFT),
        .ENTRY_SHIFT (ENTRY_SHIFT)
    ) u_lookup (
        .page_idx   (req_addr[ADDR_W-1:PAGE_SHIFT]),
        .tbl_base   (tbl_base),
        .tbl_limit  (tbl_limit),
        .in_range   (in_range),
        .entry_addr (entry_addr)
    );

    dma_xlate_ctrl #(
        .ADDR_W     (ADDR_W),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_off    (req_addr[PAGE_SHIFT-1:0]),
        .in_range   (in_range),
        .entry_addr (entry_addr),
        .rsp_valid  (rsp_valid),
        .rsp_ready  (rsp_ready),
        .rsp_paddr  (rsp_paddr),
        .rsp_fault  (rsp_fault),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_ack    (mem_ack),
        .mem_frame  (mem_rdata[ADDR_W-1:ADDR_W-IDX_W]),
        .mem_err    (mem_err)
    );
endmodule

// File: tb/dma_xlate_bench.sv
`timescale 1ns/1ps
module dma_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0, reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_err = 1'b0;

    always #2.5 clk = ~clk;

    dma_xlate u_dma_xlate (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err)
    );

    typedef struct {
        logic [31:0] paddr;
        logic        fault;
        logic        fetch;
        string       req;
    } exp_t;

    exp_t        q[$];
    int          checks = 0, errors = 0;
    logic [31:0] m_base = '0, m_limit = '0;
    logic        err_on = 1'b0;
    logic [31:0] err_ent = '0;
    int          mem_lat = 0, lat_cnt = 0, mem_seen = 0;
    logic        bp_mode = 1'b0;
    int          cyc = 0;
    logic        hold_pend = 1'b0;
    logic [31:0] hold_paddr;
    logic        hold_fault;

    function automatic logic [31:0] frame_of(input logic [31:0] a);
        return {a[27:8] ^ 20'hC35A1, a[11:0] | 12'h801};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (sel) m_limit = d; else m_base = d;
    endtask

    // Driver: predicts the result, queues it, then hands the request over.
    task automatic xlate(input logic [31:0] a, input string tag);
        exp_t        e;
        logic [31:0] idx, ent, f;
        idx = {12'b0, a[31:12]};
        ent = (m_base & 32'h7FFF_FFFF) + (idx << 3);
        e.req = tag;
        if (idx < (m_limit >> 3)) begin
            e.fetch = 1'b1;
            if (err_on && ent == err_ent) begin
                e.paddr = '0; e.fault = 1'b1;
            end else begin
                f = frame_of(ent);
                e.paddr = {f[31:12], a[11:0]}; e.fault = 1'b0;
            end
        end else begin
            e.fetch = 1'b0; e.paddr = '0; e.fault = 1'b1;
        end
        q.push_back(e);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 ready low in flight", {31'b0, req_ready}, 32'd0);
    endtask

    // Memory model, consumer and scoreboard monitor
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            rsp_ready = bp_mode ? (cyc % 3 == 0) : 1'b1;
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (lat_cnt >= mem_lat) begin
                    mem_ack   = 1'b1;
                    mem_rdata = frame_of(mem_addr);
                    mem_err   = err_on && (mem_addr == err_ent);
                    mem_seen++;
                    lat_cnt   = 0;
                end else begin
                    lat_cnt++;
                end
            end
            if (hold_pend) begin
                chk("R7 held valid", {31'b0, rsp_valid}, 32'd1);
                chk("R7 held paddr", rsp_paddr, hold_paddr);
                chk("R7 held fault", {31'b0, rsp_fault}, {31'b0, hold_fault});
                hold_pend = 1'b0;
            end
            if (rsp_valid && !rsp_ready) begin
                hold_pend  = 1'b1;
                hold_paddr = rsp_paddr;
                hold_fault = rsp_fault;
            end
            if (rsp_valid && rsp_ready) begin
                if (q.size() == 0) begin
                    chk("R2 unexpected response", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk({e.req, " paddr"}, rsp_paddr, e.paddr);
                    chk({e.req, " fault"}, {31'b0, rsp_fault}, {31'b0, e.fault});
                    chk({e.req, " reads"}, mem_seen, e.fetch ? 32'd1 : 32'd0);
                end
                mem_seen = 0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 req_ready", {31'b0, req_ready}, 32'd1);
        chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
        chk("R1 mem_req", {31'b0, mem_req}, 32'd0);
        xlate(32'h0000_0123, "R1 reset limit faults");

        // R8 program base (top bit set, must be masked) and 8 slots
        wr_reg(1'b0, 32'h8000_1000);
        wr_reg(1'b1, 32'h0000_0040);
        xlate(32'h0000_0ABC, "R5 page0");
        xlate(32'h0000_7123, "R4 last slot");
        xlate(32'h0000_8000, "R3 index equals count");
        wr_reg(1'b1, 32'h0000_0047);
        xlate(32'h0000_8FFF, "R3 limit floor");
        wr_reg(1'b1, 32'h0000_0048);
        xlate(32'h0000_8FFF, "R3 first slot past boundary");

        // R6 read error on one slot
        err_on = 1'b1; err_ent = 32'h0000_1010;
        xlate(32'h0000_2456, "R6 read error");
        xlate(32'h0000_3456, "R5 neighbour of error");
        err_on = 1'b0;

        // Varied latency with a stalling consumer
        bp_mode = 1'b1;
        for (int i = 0; i < 8; i++) begin
            mem_lat = i % 4;
            xlate({20'(i), 12'(i * 291)}, "R7 backpressure");
        end
        bp_mode = 1'b0;

        // Highest index, carry into bit 31 of the slot address
        wr_reg(1'b0, 32'hFFFF_F000);
        wr_reg(1'b1, 32'hFFFF_FFFF);
        mem_lat = 1;
        xlate(32'hFFFF_F123, "R4 top index wrap");

        // Register write during a fetch only affects later requests
        wr_reg(1'b0, 32'h0004_0000);
        mem_lat = 6;
        xlate(32'h0000_5A5A, "R8 in-flight old regs");
        wr_reg(1'b1, 32'h0000_0010);
        wr_reg(1'b0, 32'h0009_0000);
        xlate(32'h0000_5A5A, "R8 new limit applies");
        xlate(32'h0000_1A5A, "R8 new base applies");

        repeat (30) @(negedge clk);
        chk("R2 all responses seen", q.size(), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule